// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into tags from a pool of 64 temporary registers. It handles one instruction per cycle, in program order. Each instruction offers two source register numbers, an optional destination register number and a valid flag. For each source the block returns the tag of the most recent instruction that wrote that register. Each destination gets a newly allocated tag, and the map records it so that later readers find the new producer. Because every write of an architectural register gets a fresh tag, a loop body issued again and again gets distinct temporary registers in each iteration, while true read-after-write chains are kept.

There are 9 architectural registers. After reset or flush, register i maps to tag i. Destination tags come from a sequential counter. It starts at tag 9, climbs to 63 and wraps back to 9. An external count of tags still in use tells the block when the 55-entry allocation pool is exhausted. When it is, the block raises `full` and accepts nothing. Results are registered: they appear one cycle after the instruction is accepted.

Top module: `reg_rename_table`

## Requirements
- R1: After reset, a source naming architectural register i (0 to 8) returns tag i.
- R2: The first destination after reset or flush receives tag 9. Each later destination receives the previous destination tag plus one.
- R3: The destination tag that follows tag 63 is tag 9. Tags 0 to 8 are never allocated to a destination.
- R4: A source returns the tag given to the most recent earlier destination that named the same architectural register.
- R5: Within one instruction, sources are looked up before that instruction's own destination write. A source equal to the destination returns the older tag.
- R6: An instruction with `in_dst_en` = 0 reports `out_dst_en` = 0, consumes no tag and leaves the map unchanged. Its sources are still translated.
- R7: `out_valid` is 1 in the cycle after a cycle with `in_valid` and `in_ready` both 1, and 0 after any other cycle. The output tags belong to that accepted instruction.
- R8: When `in_live_count` is 55 or more, `full` is 1 and `in_ready` is 0. An instruction offered then is not accepted, and neither the map nor the counter changes.
- R9: A cycle with `flush` = 1 returns the map to its reset state and the counter to 9. It drops `in_ready` in that cycle and leaves `out_valid` at 0 in the next cycle.
- R10: While the in-use count stays below 55, no tag is handed out again within 55 consecutive allocations. Live destinations therefore never share a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Restore the identity map and the first tag |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The block can accept an instruction this cycle |
| in_src0 | input | 4 | First source architectural register (0 to 8) |
| in_src1 | input | 4 | Second source architectural register (0 to 8) |
| in_dst_en | input | 1 | The instruction writes a destination |
| in_dst | input | 4 | Destination architectural register (0 to 8) |
| in_live_count | input | 7 | Number of allocated tags still in use |
| full | output | 1 | No tag is free for allocation |
| out_valid | output | 1 | The renamed result is valid this cycle |
| out_src0_tag | output | 6 | Tag for the first source |
| out_src1_tag | output | 6 | Tag for the second source |
| out_dst_en | output | 1 | The renamed instruction has a destination |
| out_dst_tag | output | 6 | Newly allocated destination tag |

## Verification
The properties assume that register numbers stay in the range 0 to 8. They also assume that `in_live_count` reflects the real number of tags in use, so that the sequential counter never reaches a tag that is still live. The stimulus only uses register numbers 0 to 8. It holds the in-use count at zero while it runs the repeated loop body through the wrap. It raises the count to the pool size only in the stall test, where the block must refuse every instruction. Flush is applied only in cycles chosen to show that the pending offer is dropped.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    localparam int NUM_TAGS  = 64;
    localparam int ARCH_REGS = 9;
    localparam int NUM_RD    = 2;

    localparam int TAG_W     = $clog2(NUM_TAGS);
    localparam int ARCH_W    = $clog2(ARCH_REGS);
    localparam int CNT_W     = $clog2(NUM_TAGS + 1);
    localparam int FIRST_TAG = ARCH_REGS;
    localparam int LAST_TAG  = NUM_TAGS - 1;
    localparam int POOL_SIZE = NUM_TAGS - FIRST_TAG;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [ARCH_W-1:0] arch_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        arch_t src0;
        arch_t src1;
        logic  dst_en;
        arch_t dst;
    } rename_req_t;

    typedef struct packed {
        tag_t src0_tag;
        tag_t src1_tag;
        logic dst_en;
        tag_t dst_tag;
    } rename_rsp_t;

    function automatic tag_t advance_tag(input tag_t cur);
        if (cur == tag_t'(LAST_TAG))
            return tag_t'(FIRST_TAG);
        return cur + tag_t'(1);
    endfunction

    function automatic logic pool_exhausted(input cnt_t live);
        return live >= cnt_t'(POOL_SIZE);
    endfunction

endpackage

// File: rtl/rrt_map.sv
module rrt_map
    import rrt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  arch_t rd_idx [NUM_RD],
    output tag_t  rd_tag [NUM_RD],
    input  logic  wr_en,
    input  arch_t wr_idx,
    input  tag_t  wr_tag
);

    tag_t map_q [ARCH_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < ARCH_REGS; i++) begin
            if (rst || clear)
                map_q[i] <= tag_t'(i);
            else if (wr_en && (wr_idx == arch_t'(i)))
                map_q[i] <= wr_tag;
        end
    end

    // Read ports see the stored state only, so a same-cycle write is not visible.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_tag[p] = '0;
            for (int i = 0; i < ARCH_REGS; i++) begin
                if (rd_idx[p] == arch_t'(i))
                    rd_tag[p] = map_q[i];
            end
        end
    end

endmodule

// File: rtl/rrt_alloc.sv
module rrt_alloc
    import rrt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic take,
    input  cnt_t live_count,
    output tag_t cur_tag,
    output logic exhausted
);

    tag_t next_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            next_q <= tag_t'(FIRST_TAG);
        else if (take)
            next_q <= advance_tag(next_q);
    end

    assign cur_tag   = next_q;
    assign exhausted = pool_exhausted(live_count);

endmodule

// File: rtl/rrt_outreg.sv
module rrt_outreg
    import rrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  rename_rsp_t rsp_d,
    output logic        valid_q,
    output rename_rsp_t rsp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= load;
            if (load)
                rsp_q <= rsp_d;
        end
    end

endmodule

// File: rtl/reg_rename_table.sv
module reg_rename_table
    import rrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ARCH_W-1:0] in_src0,
    input  logic [ARCH_W-1:0] in_src1,
    input  logic              in_dst_en,
    input  logic [ARCH_W-1:0] in_dst,
    input  logic [CNT_W-1:0]  in_live_count,
    output logic              full,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_src0_tag,
    output logic [TAG_W-1:0]  out_src1_tag,
    output logic              out_dst_en,
    output logic [TAG_W-1:0]  out_dst_tag
);

    rename_req_t req;
    rename_rsp_t rsp_d;
    rename_rsp_t rsp_q;
    arch_t       rd_idx [NUM_RD];
    tag_t        rd_tag [NUM_RD];
    tag_t        alloc_tag;
    logic        exhausted;
    logic        accept;
    logic        valid_q;

    assign req.src0   = in_src0;
    assign req.src1   = in_src1;
    assign req.dst_en = in_dst_en;
    assign req.dst    = in_dst;

    assign in_ready = !rst && !flush && !exhausted;
    assign accept   = in_valid && in_ready;
    assign full     = exhausted;

    assign rd_idx[0] = req.src0;
    assign rd_idx[1] = req.src1;

    rrt_map u_map (
        .clk    (clk),
        .rst    (rst),
        .clear  (flush),
        .rd_idx (rd_idx),
        .rd_tag (rd_tag),
        .wr_en  (accept && req.dst_en),
        .wr_idx (req.dst),
        .wr_tag (alloc_tag)
    );

    rrt_alloc u_alloc (
        .clk        (clk),
        .rst        (rst),
        .clear      (flush),
        .take       (accept && req.dst_en),
        .live_count (in_live_count),
        .cur_tag    (alloc_tag),
        .exhausted  (exhausted)
    );

    always_comb begin
        rsp_d.src0_tag = rd_tag[0];
        rsp_d.src1_tag = rd_tag[1];
        rsp_d.dst_en   = req.dst_en;
        rsp_d.dst_tag  = req.dst_en ? alloc_tag : '0;
    end

    rrt_outreg u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .rsp_d   (rsp_d),
        .valid_q (valid_q),
        .rsp_q   (rsp_q)
    );

    assign out_valid    = valid_q;
    assign out_src0_tag = rsp_q.src0_tag;
    assign out_src1_tag = rsp_q.src1_tag;
    assign out_dst_en   = rsp_q.dst_en;
    assign out_dst_tag  = rsp_q.dst_tag;

endmodule

// File: rtl/rrt_checker.sv
module rrt_checker
    import rrt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       in_valid,
    input logic       in_ready,
    input logic       full,
    input logic       out_valid,
    input logic       out_dst_en,
    input tag_t       out_dst_tag,
    input cnt_t       in_live_count
);

    tag_t exp_dst;

    always_ff @(posedge clk) begin
        if (rst || flush)
            exp_dst <= tag_t'(FIRST_TAG);
        else if (out_valid && out_dst_en)
            exp_dst <= advance_tag(exp_dst);
    end

    p_accept_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_idle_novalid_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_valid);

    p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (in_live_count >= cnt_t'(POOL_SIZE)) |-> (full && !in_ready));

    p_dst_sequence_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dst_en) |-> (out_dst_tag == exp_dst));

    p_dst_range_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dst_en) |-> (out_dst_tag >= tag_t'(FIRST_TAG)));

    p_flush_drop_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);

endmodule

bind reg_rename_table rrt_checker u_rrt_checker (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .full          (full),
    .out_valid     (out_valid),
    .out_dst_en    (out_dst_en),
    .out_dst_tag   (out_dst_tag),
    .in_live_count (in_live_count)
);

// File: tb/reg_rename_table_bench.sv
module reg_rename_table_bench;
    import rrt_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              flush;
    logic              in_valid;
    logic              in_ready;
    logic [ARCH_W-1:0] in_src0;
    logic [ARCH_W-1:0] in_src1;
    logic              in_dst_en;
    logic [ARCH_W-1:0] in_dst;
    logic [CNT_W-1:0]  in_live_count;
    logic              full;
    logic              out_valid;
    logic [TAG_W-1:0]  out_src0_tag;
    logic [TAG_W-1:0]  out_src1_tag;
    logic              out_dst_en;
    logic [TAG_W-1:0]  out_dst_tag;

    int vectors = 0;
    int miscompares = 0;

    int rmap [ARCH_REGS];
    int rnext;
    int seq;
    int last_seq [NUM_TAGS];

    always #5 clk = ~clk;

    reg_rename_table u_reg_rename_table (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_src0       (in_src0),
        .in_src1       (in_src1),
        .in_dst_en     (in_dst_en),
        .in_dst        (in_dst),
        .in_live_count (in_live_count),
        .full          (full),
        .out_valid     (out_valid),
        .out_src0_tag  (out_src0_tag),
        .out_src1_tag  (out_src1_tag),
        .out_dst_en    (out_dst_en),
        .out_dst_tag   (out_dst_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void ref_reset();
        for (int i = 0; i < ARCH_REGS; i++) rmap[i] = i;
        rnext = FIRST_TAG;
        for (int t = 0; t < NUM_TAGS; t++) last_seq[t] = -1000;
    endfunction

    // Offer one instruction, let it be accepted, and compare the registered result.
    task automatic issue(input int s0, input int s1, input bit de, input int d, input string req);
        int e0, e1, ed;
        bit wrapped;
        e0 = rmap[s0];
        e1 = rmap[s1];
        ed = rnext;
        wrapped = (ed == FIRST_TAG) && (seq > 0);
        in_src0 = ARCH_W'(s0);
        in_src1 = ARCH_W'(s1);
        in_dst_en = de;
        in_dst = ARCH_W'(d);
        in_valid = 1'b1;
        #1;
        chk("R8", "in_ready with pool free", int'(in_ready), 1);
        @(posedge clk);
        if (de) begin
            vectors++;
            if (seq - last_seq[ed] < POOL_SIZE) begin
                miscompares++;
                $display("FAIL R10 tag reuse: actual gap %0d expected at least %0d",
                         seq - last_seq[ed], POOL_SIZE);
            end
            last_seq[ed] = seq;
            seq++;
            rmap[d] = ed;
            rnext = (rnext == LAST_TAG) ? FIRST_TAG : rnext + 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7", "out_valid after accept", int'(out_valid), 1);
        chk(req, "src0 tag", int'(out_src0_tag), e0);
        chk(req, "src1 tag", int'(out_src1_tag), e1);
        chk("R6", "out_dst_en", int'(out_dst_en), int'(de));
        if (de) chk(wrapped ? "R3" : "R2", "dst tag", int'(out_dst_tag), ed);
    endtask

    task automatic test_reset_identity();
        chk("R7", "out_valid after reset", int'(out_valid), 0);
        chk("R8", "full after reset", int'(full), 0);
        for (int i = 0; i < ARCH_REGS; i++) issue(i, (i + 4) % ARCH_REGS, 1'b0, 0, "R1");
        @(negedge clk);
        chk("R7", "out_valid after idle cycle", int'(out_valid), 0);
    endtask

    task automatic test_first_and_nodst();
        issue(3, 3, 1'b0, 5, "R6");
        issue(1, 0, 1'b1, 5, "R2");
        issue(5, 2, 1'b0, 6, "R6");
        issue(5, 4, 1'b1, 6, "R4");
    endtask

    task automatic test_same_instr();
        issue(2, 2, 1'b1, 2, "R5");
        issue(2, 6, 1'b0, 0, "R4");
    endtask

    // Loop body: load, divide, multiply, load, add, add, two pointer bumps, store, compare, branch.
    task automatic test_loop(input int iters);
        for (int it = 0; it < iters; it++) begin
            issue(5, 5, 1'b1, 2, "R4");
            issue(2, 0, 1'b1, 8, "R4");
            issue(6, 2, 1'b1, 2, "R5");
            issue(7, 7, 1'b1, 4, "R4");
            issue(0, 4, 1'b1, 4, "R4");
            issue(8, 2, 1'b1, 3, "R4");
            issue(5, 5, 1'b1, 5, "R4");
            issue(7, 7, 1'b1, 7, "R4");
            issue(4, 7, 1'b0, 0, "R6");
            issue(6, 5, 1'b1, 1, "R4");
            issue(1, 1, 1'b0, 0, "R6");
        end
    endtask

    task automatic test_full_stall();
        @(negedge clk);
        in_live_count = CNT_W'(POOL_SIZE);
        in_src0 = ARCH_W'(3);
        in_src1 = ARCH_W'(3);
        in_dst_en = 1'b1;
        in_dst = ARCH_W'(3);
        in_valid = 1'b1;
        #1;
        chk("R8", "full at pool size", int'(full), 1);
        chk("R8", "in_ready at pool size", int'(in_ready), 0);
        @(negedge clk);
        chk("R8", "out_valid while stalled", int'(out_valid), 0);
        @(negedge clk);
        chk("R8", "out_valid while stalled again", int'(out_valid), 0);
        in_valid = 1'b0;
        in_live_count = CNT_W'(POOL_SIZE - 1);
        #1;
        chk("R8", "full below pool size", int'(full), 0);
        in_live_count = '0;
        issue(3, 3, 1'b1, 3, "R8");
    endtask

    task automatic test_flush();
        @(negedge clk);
        flush = 1'b1;
        in_src0 = ARCH_W'(2);
        in_src1 = ARCH_W'(4);
        in_dst_en = 1'b1;
        in_dst = ARCH_W'(2);
        in_valid = 1'b1;
        #1;
        chk("R9", "in_ready during flush", int'(in_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b0;
        chk("R9", "out_valid after flush", int'(out_valid), 0);
        ref_reset();
        seq = 0;
        issue(2, 8, 1'b0, 0, "R9");
        issue(5, 7, 1'b1, 2, "R9");
        issue(2, 1, 1'b0, 0, "R4");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1;
        flush = 1'b0;
        in_valid = 1'b0;
        in_src0 = '0;
        in_src1 = '0;
        in_dst_en = 1'b0;
        in_dst = '0;
        in_live_count = '0;
        ref_reset();
        seq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset_identity();
        test_first_and_nodst();
        test_same_instr();
        test_loop(8);
        test_full_stall();
        test_flush();
        test_loop(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule